// File: doc/BRIEF.md
# Byte Access Adapter for Word-Wide Memory

This block lets a requester read and write single bytes in a memory that only moves whole words. The requester gives a byte address, a direction flag and, for a store, one data byte, using a valid/ready handshake. The adapter splits the address into a word index and a lane number. It then runs the word accesses on a plain synchronous memory port. The memory returns read data one cycle after the read strobe.

A byte load fetches the word that holds the byte and returns the chosen lane, zero-extended to the width of a word. The memory has no byte enables, so a byte store is a read-modify-write: the adapter fetches the word, puts the new byte into the chosen lane, and writes the whole word back. Each result is marked by a one-cycle done pulse. After that pulse the adapter spends one recovery cycle before it takes the next request, so the spacing between requests is longer than the latency of any single request. Lanes are little-endian: lane 0 is bits 7:0.

Top module: `byteacc_adapter`

## Requirements
- R1: `req_ready` is high only when the adapter is idle. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. While `req_ready` is high, `rsp_done`, `mem_rd` and `mem_wr` are all low.
- R2: Every memory access carries the word index, which is the byte address with its two low bits dropped (the byte address divided by 4). The read strobe comes in the cycle right after a request is taken.
- R3: A load makes exactly one memory read and no memory write. `rsp_done` pulses three cycles after the request is taken. `rsp_rdata` then holds the byte from lane `addr[1:0]` (lane k is bits 8k+7:8k), with all upper bits zero.
- R4: A store makes exactly one memory read followed by exactly one memory write to the same word, two cycles after the read strobe. The written word equals the word that was read, with only lane `addr[1:0]` replaced by `req_wdata`. The other three lanes are unchanged.
- R5: For a store, `rsp_done` pulses four cycles after the request is taken, and `rsp_rdata` is zero during that pulse.
- R6: In the cycle after `rsp_done`, `req_ready` is low (recovery). In the cycle after that, `req_ready` is high again.
- R7: While in reset and right after it, `req_ready` is 1 and `rsp_done`, `mem_rd` and `mem_wr` are 0.
- R8: `mem_rd` and `mem_wr` are never high together. A `req_valid` raised while the adapter is busy is ignored: it causes no memory access and does not change the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle and able to take a request |
| req_write | input | 1 | 1 = byte store, 0 = byte load |
| req_addr | input | ADDR_W (16) | Byte address |
| req_wdata | input | BYTE_W (8) | Byte to store |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (32) | Loaded byte, zero-extended; zero for stores |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W-2 (14) | Word index |
| mem_wdata | output | DATA_W (32) | Full word to write |
| mem_rdata | input | DATA_W (32) | Word read data, valid the cycle after `mem_rd` |

## Verification
The hardest case to reach from the ports is a requester that keeps `req_valid` high while a transaction is still running, right through the read, merge and response cycles. A normal requester never does this. The bench drives it on purpose: it raises `req_valid` with a different address in every busy cycle. It then confirms that only one memory read happened and that the word at the other address is untouched. The bench also checks that untouched lanes survive a merge. To do this it stores into all four lane positions and into words reached through high address bits, and compares the memory model with its own shadow copy after each store.

// File: rtl/byteacc_pkg.sv
package byteacc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ISSUE = 3'd1,
        ST_RD_WAIT  = 3'd2,
        ST_MERGE_WR = 3'd3,
        ST_RESPOND  = 3'd4,
        ST_RECOVER  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/byteacc_split.sv
module byteacc_split #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 2
) (
    input  logic [ADDR_W-1:0]       byte_addr,
    output logic [ADDR_W-OFS_W-1:0] word_idx,
    output logic [OFS_W-1:0]        lane_idx
);
    // Power-of-two word size: split is pure wiring.
    assign word_idx = byte_addr[ADDR_W-1:OFS_W];
    assign lane_idx = byte_addr[OFS_W-1:0];
endmodule

// File: rtl/byteacc_lane.sv
module byteacc_lane #(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    localparam int DATA_W    = BYTE_W * WORD_BYTES,
    localparam int OFS_W     = $clog2(WORD_BYTES)
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [OFS_W-1:0]  lane_sel,
    input  logic [BYTE_W-1:0] new_byte,
    output logic [BYTE_W-1:0] byte_out,
    output logic [DATA_W-1:0] merged
);
    assign byte_out = word_in[lane_sel*BYTE_W +: BYTE_W];

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign merged[g*BYTE_W +: BYTE_W] =
            (lane_sel == OFS_W'(g)) ? new_byte : word_in[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/byteacc_adapter.sv
module byteacc_adapter
    import byteacc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    localparam int DATA_W    = BYTE_W * WORD_BYTES,
    localparam int OFS_W     = $clog2(WORD_BYTES),
    localparam int WADDR_W   = ADDR_W - OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BYTE_W-1:0]  req_wdata,
    output logic               rsp_done,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);

    typedef struct packed {
        seq_state_e         state;
        logic [WADDR_W-1:0] widx;
        logic [OFS_W-1:0]   lane;
        logic               is_wr;
        logic [BYTE_W-1:0]  wbyte;
        logic [DATA_W-1:0]  word;
        logic [DATA_W-1:0]  rdata;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    logic [WADDR_W-1:0] in_widx;
    logic [OFS_W-1:0]   in_lane;
    logic [BYTE_W-1:0]  picked;
    logic [DATA_W-1:0]  merged;

    byteacc_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_split (
        .byte_addr (req_addr),
        .word_idx  (in_widx),
        .lane_idx  (in_lane)
    );

    byteacc_lane #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_lane (
        .word_in  (mem_rdata),
        .lane_sel (cur_q.lane),
        .new_byte (cur_q.wbyte),
        .byte_out (picked),
        .merged   (merged)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.state = ST_RD_ISSUE;
                    nxt_d.widx  = in_widx;
                    nxt_d.lane  = in_lane;
                    nxt_d.is_wr = req_write;
                    nxt_d.wbyte = req_wdata;
                    nxt_d.rdata = '0;
                end
            end
            ST_RD_ISSUE: nxt_d.state = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (cur_q.is_wr) begin
                    nxt_d.word  = merged;
                    nxt_d.state = ST_MERGE_WR;
                end else begin
                    nxt_d.rdata = DATA_W'(picked);
                    nxt_d.state = ST_RESPOND;
                end
            end
            ST_MERGE_WR: nxt_d.state = ST_RESPOND;
            ST_RESPOND:  nxt_d.state = ST_RECOVER;
            ST_RECOVER: begin
                nxt_d.state = ST_IDLE;
                nxt_d.rdata = '0;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = (cur_q.state == ST_IDLE);
    assign rsp_done  = (cur_q.state == ST_RESPOND);
    assign rsp_rdata = rsp_done ? cur_q.rdata : '0;
    assign mem_rd    = (cur_q.state == ST_RD_ISSUE);
    assign mem_wr    = (cur_q.state == ST_MERGE_WR);
    assign mem_addr  = cur_q.widx;
    assign mem_wdata = cur_q.word;

endmodule

// File: rtl/byteacc_chk.sv
module byteacc_chk #(
    parameter int WADDR_W = 14,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [WADDR_W-1:0] req_widx,
    input logic               rsp_done,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic [WADDR_W-1:0] mem_addr
);
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_done && !mem_rd && !mem_wr)); // R1
    AST_ISSUE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd && mem_addr == $past(req_widx))); // R2
    AST_LOAD_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !$past(mem_wr)) |-> $past(mem_rd, 2)); // R3
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2))); // R4
    AST_STORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && $past(mem_wr)) |-> rsp_rdata == '0); // R5
    AST_RECOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !req_ready); // R6
    AST_RECOVER_END: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ##2 req_ready); // R6
    AST_NO_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R8
endmodule

bind byteacc_adapter byteacc_chk #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_widx  (req_addr[ADDR_W-1:OFS_W]),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr)
);

// File: tb/byteacc_adapter_tb.sv
module byteacc_adapter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        mem_rd, mem_wr;
    logic [13:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    always #2 clk = ~clk; // 250 MHz

    byteacc_adapter u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] bmem [16];
    logic [31:0] smem [16];
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [13:0] last_rd_addr;
    logic [13:0] last_wr_addr;

    function automatic logic [31:0] seed_word(int i);
        return 32'h1357_9BDF ^ (32'h0101_0101 * i);
    endfunction

    // Memory model: word port, one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) bmem[i] <= seed_word(i);
            mem_rdata <= '0;
        end else begin
            if (mem_rd) mem_rdata <= bmem[mem_addr[3:0]];
            if (mem_wr) bmem[mem_addr[3:0]] <= mem_wdata;
        end
    end

    always @(posedge clk) begin
        if (rst_n && mem_rd) begin rd_cnt <= rd_cnt + 1; last_rd_addr <= mem_addr; end
        if (rst_n && mem_wr) begin wr_cnt <= wr_cnt + 1; last_wr_addr <= mem_addr; end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // wr, addr, data
    localparam int NV = 12;
    localparam logic [24:0] VECS [NV] = '{
        {1'b0, 16'h0000, 8'h00},
        {1'b0, 16'h0001, 8'h00},
        {1'b0, 16'h0002, 8'h00},
        {1'b0, 16'h0003, 8'h00},
        {1'b1, 16'h0006, 8'hA5},
        {1'b0, 16'h0006, 8'h00},
        {1'b0, 16'h0005, 8'h00},
        {1'b1, 16'h0004, 8'h3C},
        {1'b1, 16'hFFFF, 8'hE7},
        {1'b0, 16'h003F, 8'h00},
        {1'b1, 16'h8029, 8'h00},
        {1'b0, 16'h0029, 8'h00}
    };

    task automatic run_op(input logic wr, input logic [15:0] a, input logic [7:0] d);
        int lat;
        int rd0, wr0;
        logic [31:0] expw;
        logic [31:0] expr;
        logic [3:0]  wi;
        wi = a[5:2];
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 20) begin @(negedge clk); lat++; end
        if (!wr) begin
            expr = {24'h0, smem[wi][a[1:0]*8 +: 8]};
            check(lat == 3, "R3 load latency", lat, 3);
            check(rsp_rdata == expr, "R3 load data", rsp_rdata, expr);
            check(rd_cnt - rd0 == 1 && wr_cnt == wr0, "R3 one read no write", rd_cnt - rd0, 1);
        end else begin
            expw = smem[wi];
            expw[a[1:0]*8 +: 8] = d;
            smem[wi] = expw;
            check(lat == 4, "R5 store latency", lat, 4);
            check(rsp_rdata == 0, "R5 store rdata zero", rsp_rdata, 0);
            check(rd_cnt - rd0 == 1 && wr_cnt - wr0 == 1, "R4 one read one write", wr_cnt - wr0, 1);
            check(bmem[wi] == expw, "R4 merged word", bmem[wi], expw);
            check(last_wr_addr == a[15:2], "R2 write word index", 32'(last_wr_addr), 32'(a[15:2]));
        end
        check(last_rd_addr == a[15:2], "R2 read word index", 32'(last_rd_addr), 32'(a[15:2]));
        @(negedge clk);
        check(req_ready == 1'b0, "R6 recovery cycle", 32'(req_ready), 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R6 ready after recovery", 32'(req_ready), 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) smem[i] = seed_word(i);
        repeat (3) @(negedge clk);
        // R7: reset state
        check(req_ready == 1'b1 && rsp_done == 1'b0 && !mem_rd && !mem_wr,
              "R7 in reset", {req_ready, rsp_done, mem_rd, mem_wr}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_done == 1'b0 && !mem_rd && !mem_wr,
              "R7 after reset", {req_ready, rsp_done, mem_rd, mem_wr}, 4'b1000);

        for (int v = 0; v < NV; v++) begin
            run_op(VECS[v][24], VECS[v][23:8], VECS[v][7:0]);
        end

        // R1/R8: valid held high with another address while busy is ignored
        begin
            int rd0, wr0;
            logic [31:0] other;
            other = bmem[9];
            rd0 = rd_cnt; wr0 = wr_cnt;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0010; req_wdata = 8'h5A;
            @(negedge clk);
            req_write = 1'b1; req_addr = 16'h0024; req_wdata = 8'hFF;
            while (!rsp_done) @(negedge clk);
            req_valid = 1'b0;
            smem[4][7:0] = 8'h5A;
            check(rd_cnt - rd0 == 1 && wr_cnt - wr0 == 1, "R8 busy valid ignored",
                  rd_cnt - rd0 + wr_cnt - wr0, 2);
            check(bmem[9] == other, "R8 other word untouched", bmem[9], other);
            check(bmem[4] == smem[4], "R1 accepted store lands", bmem[4], smem[4]);
            repeat (2) @(negedge clk);
            check(rd_cnt - rd0 == 1, "R1 no second acceptance", rd_cnt - rd0, 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule